// File: doc/BRIEF.md
# Paged MDIO Register Window Bridge

This block sits behind an MDIO management slave and lets a clause-22 host reach a 32-bit internal register space using only 16-bit MDIO registers. The host first stores a page number through a dedicated page register. It then reaches any 32-bit word on that page through a group of PHY addresses that act as register windows. The serial MDIO framing is decoded elsewhere. This block receives one decoded transaction per `mdio_valid` pulse, with PHY address, register number, direction and write data.

The internal byte address is built from three parts: the stored page, the low three bits of the window PHY address, and the upper four bits of the MDIO register number. An even register number holds the low half of the word and the odd register after it holds the high half. A 32-bit write goes out on the internal bus only when the high half arrives. A low-half read performs one internal read and keeps the upper half for the matching high-half read.

Top module: `mdio_page_bridge`

## Requirements
- R1: A write to PHY address 0x18, register 0 loads write data bits [9:0] into the page register. Higher data bits are dropped. The page resets to 0. A read of PHY 0x18, register 0 returns the page zero-extended to 16 bits.
- R2: During every internal strobe, `bus_addr` holds the following fields. Bits [18:9] are the page. Bits [8:6] are PHY address bits [2:0]. Bits [5:2] are register number bits [4:1]. Bits [1:0] are 0, and all bits above 18 are 0.
- R3: A write to an even register in a window (PHY 0x10 to 0x17) only stages the 16-bit data. It produces no internal strobe.
- R4: A write to an odd register in a window pulses `bus_wr` for exactly one cycle, in the cycle after the transaction is accepted. `bus_wdata` is {this write's data, last staged low half}.
- R5: A read of an even register in a window pulses `bus_rd` for one cycle, in the cycle after acceptance. The response carries `bus_rdata[15:0]` as sampled during that pulse.
- R6: A read of an odd register in a window returns the upper 16 bits captured by the latest low-half read. It does not strobe `bus_rd`. Before any capture this value is 0.
- R7: Transactions to any other address have no effect: no strobe and no page change. This covers PHY addresses outside 0x10 to 0x18, and PHY 0x18 with a register other than 0. Reads of these addresses return 0xFFFF.
- R8: Every read transaction produces exactly one `mdio_rvalid` pulse, two cycles after acceptance. Write transactions produce no pulse.
- R9: `bus_wr` and `bus_rd` are never high in the same cycle, and all strobes and `mdio_rvalid` are low during and right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mdio_valid | input | 1 | One-cycle pulse: a decoded MDIO transaction is present |
| mdio_write | input | 1 | 1 = write transaction, 0 = read |
| mdio_phy | input | 5 | MDIO PHY address of the transaction |
| mdio_reg | input | 5 | MDIO register number of the transaction |
| mdio_wdata | input | 16 | Write data of the transaction |
| mdio_rvalid | output | 1 | Read response valid pulse |
| mdio_rdata | output | 16 | Read response data |
| bus_addr | output | 32 | Internal byte address |
| bus_wdata | output | 32 | Internal write data |
| bus_wr | output | 1 | Internal write strobe |
| bus_rd | output | 1 | Internal read strobe |
| bus_rdata | input | 32 | Internal read data, valid in the `bus_rd` cycle |

## Verification
The bench uses the default parameters: a 10-bit page, 16-bit halves and a 32-bit internal bus. With these values the page field reaches its full 0x3FF width, and an over-wide page write shows that its upper bits are truncated. All eight window PHY addresses are exercised with all sixteen word offsets on several pages. Back-to-back transactions are mixed in, so a high-half read can follow its low-half read in the very next cycle. That case puts the capture register on its tightest timing.

// File: rtl/mpb_pkg.sv
package mpb_pkg;
  typedef enum logic [2:0] {
    RK_NONE,
    RK_LOW,
    RK_HIGH,
    RK_PAGE,
    RK_VOID
  } rd_kind_t;
endpackage

// File: rtl/mpb_decode.sv
module mpb_decode #(
  parameter int PHY_W    = 5,
  parameter int REG_W    = 5,
  parameter int PAGE_W   = 10,
  parameter int ADDR_W   = 32,
  parameter logic [4:0] PAGE_PHY = 5'h18,
  parameter logic [4:0] WIN_PHY  = 5'h10
) (
  input  logic [PHY_W-1:0]  phy,
  input  logic [REG_W-1:0]  regnum,
  input  logic [PAGE_W-1:0] page_q,
  output logic              is_page,
  output logic              is_win,
  output logic              hi_half,
  output logic [ADDR_W-1:0] word_addr
);
  localparam int SEL_W  = 3;
  localparam int OFF_W  = REG_W - 1;
  localparam int USED_W = PAGE_W + SEL_W + OFF_W + 2;

  assign is_page = (phy == PAGE_PHY[PHY_W-1:0]) && (regnum == '0);
  assign is_win  = (phy[PHY_W-1:SEL_W] == WIN_PHY[PHY_W-1:SEL_W]);
  assign hi_half = regnum[0];

  generate
    if (ADDR_W > USED_W) begin : g_pad
      assign word_addr = {{(ADDR_W-USED_W){1'b0}}, page_q, phy[SEL_W-1:0],
                          regnum[REG_W-1:1], 2'b00};
    end else begin : g_exact
      assign word_addr = {page_q, phy[SEL_W-1:0], regnum[REG_W-1:1], 2'b00};
    end
  endgenerate
endmodule

// File: rtl/mpb_page_reg.sv
module mpb_page_reg #(
  parameter int PAGE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [PAGE_W-1:0] load_data,
  output logic [PAGE_W-1:0] page_q
);
  always_ff @(posedge clk) begin
    if (rst)          page_q <= '0;
    else if (load_en) page_q <= load_data;
  end

  // R7
  page_only_by_load_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(page_q) |-> $past(load_en));
endmodule

// File: rtl/mpb_word_port.sv
module mpb_word_port
  import mpb_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                acc_valid,
  input  logic                acc_write,
  input  logic                is_page,
  input  logic                is_win,
  input  logic                hi_half,
  input  logic [ADDR_W-1:0]   word_addr,
  input  logic [HALF_W-1:0]   wr_half,
  input  logic [PAGE_W-1:0]   page_q,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [2*HALF_W-1:0] bus_wdata,
  output logic                bus_wr,
  output logic                bus_rd,
  input  logic [2*HALF_W-1:0] bus_rdata,
  output logic                rsp_valid,
  output logic [HALF_W-1:0]   rsp_data
);
  localparam int WORD_W = 2 * HALF_W;

  logic [HALF_W-1:0] stage_lo;
  logic [HALF_W-1:0] cap_hi;
  rd_kind_t          pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_lo  <= '0;
      cap_hi    <= '0;
      pend      <= RK_NONE;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_wr    <= 1'b0;
      bus_rd    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      bus_wr    <= 1'b0;
      bus_rd    <= 1'b0;
      rsp_valid <= (pend != RK_NONE);
      case (pend)
        RK_LOW: begin
          rsp_data <= bus_rdata[HALF_W-1:0];
          cap_hi   <= bus_rdata[WORD_W-1:HALF_W];
        end
        RK_HIGH: rsp_data <= cap_hi;
        RK_PAGE: rsp_data <= {{(HALF_W-PAGE_W){1'b0}}, page_q};
        RK_VOID: rsp_data <= '1;
        default: ;
      endcase
      pend <= RK_NONE;
      if (acc_valid) begin
        if (acc_write) begin
          if (is_win && !hi_half) stage_lo <= wr_half;
          if (is_win && hi_half) begin
            bus_wr    <= 1'b1;
            bus_addr  <= word_addr;
            bus_wdata <= {wr_half, stage_lo};
          end
        end else if (is_win && !hi_half) begin
          bus_rd   <= 1'b1;
          bus_addr <= word_addr;
          pend     <= RK_LOW;
        end else if (is_win) begin
          pend <= RK_HIGH;
        end else if (is_page) begin
          pend <= RK_PAGE;
        end else begin
          pend <= RK_VOID;
        end
      end
    end
  end

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_rd));
  // R4
  wr_from_high_chk: assert property (@(posedge clk) disable iff (rst)
    bus_wr |-> $past(acc_valid && acc_write && is_win && hi_half));
  // R5
  rd_from_low_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd |-> $past(acc_valid && !acc_write && is_win && !hi_half));
  // R3
  no_strobe_low_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_write && is_win && !hi_half) |=> !bus_wr && !bus_rd);
endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge #(
  parameter int PHY_W  = 5,
  parameter int REG_W  = 5,
  parameter int HALF_W = 16,
  parameter int PAGE_W = 10,
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mdio_valid,
  input  logic                mdio_write,
  input  logic [PHY_W-1:0]    mdio_phy,
  input  logic [REG_W-1:0]    mdio_reg,
  input  logic [HALF_W-1:0]   mdio_wdata,
  output logic                mdio_rvalid,
  output logic [HALF_W-1:0]   mdio_rdata,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [2*HALF_W-1:0] bus_wdata,
  output logic                bus_wr,
  output logic                bus_rd,
  input  logic [2*HALF_W-1:0] bus_rdata
);
  logic [PAGE_W-1:0] page_q;
  logic              is_page, is_win, hi_half;
  logic [ADDR_W-1:0] word_addr;
  logic              page_load;

  mpb_decode #(
    .PHY_W(PHY_W), .REG_W(REG_W), .PAGE_W(PAGE_W), .ADDR_W(ADDR_W)
  ) u_decode (
    .phy(mdio_phy), .regnum(mdio_reg), .page_q(page_q),
    .is_page(is_page), .is_win(is_win), .hi_half(hi_half),
    .word_addr(word_addr)
  );

  assign page_load = mdio_valid && mdio_write && is_page;

  mpb_page_reg #(.PAGE_W(PAGE_W)) u_page (
    .clk(clk), .rst(rst), .load_en(page_load),
    .load_data(mdio_wdata[PAGE_W-1:0]), .page_q(page_q)
  );

  mpb_word_port #(.HALF_W(HALF_W), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_port (
    .clk(clk), .rst(rst), .acc_valid(mdio_valid), .acc_write(mdio_write),
    .is_page(is_page), .is_win(is_win), .hi_half(hi_half),
    .word_addr(word_addr), .wr_half(mdio_wdata), .page_q(page_q),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .rsp_valid(mdio_rvalid), .rsp_data(mdio_rdata)
  );

  // R8
  rsp_latency_chk: assert property (@(posedge clk) disable iff (rst)
    mdio_rvalid |-> $past(mdio_valid && !mdio_write, 2));
  // R2
  addr_align_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr || bus_rd) |-> (bus_addr[1:0] == 2'b00));
  // R7
  void_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (mdio_valid && !is_win) |=> !bus_wr && !bus_rd);
endmodule

// File: tb/test_mdio_page_bridge.sv
`timescale 1ns/1ps
module test_mdio_page_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mdio_valid = 1'b0, mdio_write = 1'b0;
  logic [4:0]  mdio_phy = '0, mdio_reg = '0;
  logic [15:0] mdio_wdata = '0;
  logic        mdio_rvalid;
  logic [15:0] mdio_rdata;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic        bus_wr, bus_rd;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] reg_space(input logic [31:0] a);
    return (a * 32'h0001_0003) ^ 32'hC3A5_0F0F;
  endfunction

  assign bus_rdata = reg_space(bus_addr);

  mdio_page_bridge i_mdio_page_bridge (
    .clk(clk), .rst(rst), .mdio_valid(mdio_valid), .mdio_write(mdio_write),
    .mdio_phy(mdio_phy), .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata),
    .mdio_rvalid(mdio_rvalid), .mdio_rdata(mdio_rdata),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  int checks = 0, failures = 0, cycles = 0;
  bit started = 0;

  // reference model state
  int          m_page, m_stage, m_cap;
  int          pend;          // 0 none,1 low,2 high,3 page,4 void
  logic [31:0] pend_val;
  logic        e_rv, e_wr, e_rd;
  logic [15:0] e_rdata;
  logic [31:0] e_addr, e_wdata;
  string       rtag = "R8", stag = "R9";

  always @(posedge clk) begin
    cycles++;
    started = 1;
    if (rst) begin
      m_page = 0; m_stage = 0; m_cap = 0; pend = 0;
      e_rv = 0; e_wr = 0; e_rd = 0; e_rdata = 0; e_addr = 0; e_wdata = 0;
      stag = "R9";
    end else begin
      e_rv = (pend != 0);
      if (pend == 1) begin
        e_rdata = pend_val[15:0]; m_cap = int'(pend_val[31:16]); rtag = "R5";
      end else if (pend == 2) begin
        e_rdata = 16'(m_cap); rtag = "R6";
      end else if (pend == 3) begin
        e_rdata = 16'(m_page); rtag = "R1";
      end else if (pend == 4) begin
        e_rdata = 16'hFFFF; rtag = "R7";
      end
      pend = 0; e_wr = 0; e_rd = 0; stag = "R9";
      if (mdio_valid) begin
        automatic bit pg  = (mdio_phy == 5'h18) && (mdio_reg == 0);
        automatic bit win = (mdio_phy >= 5'h10) && (mdio_phy <= 5'h17);
        automatic int a   = (m_page * 512) + ((mdio_phy % 8) * 64) + ((mdio_reg / 2) * 4);
        if (mdio_write) begin
          if (pg) begin m_page = mdio_wdata % 1024; stag = "R1"; end
          else if (win && mdio_reg % 2 == 0) begin m_stage = mdio_wdata; stag = "R3"; end
          else if (win) begin
            e_wr = 1; e_addr = a; e_wdata = {mdio_wdata, 16'(m_stage)}; stag = "R4";
          end else stag = "R7";
        end else begin
          if (win && mdio_reg % 2 == 0) begin
            e_rd = 1; e_addr = a; pend = 1; pend_val = reg_space(a); stag = "R5";
          end else if (win) begin pend = 2; stag = "R6"; end
          else if (pg) pend = 3;
          else begin pend = 4; stag = "R7"; end
        end
      end
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk("R8", "mdio_rvalid", 32'(mdio_rvalid), 32'(e_rv));
      if (e_rv) chk(rtag, "mdio_rdata", 32'(mdio_rdata), 32'(e_rdata));
      chk(e_wr ? "R4" : stag, "bus_wr", 32'(bus_wr), 32'(e_wr));
      chk(e_rd ? "R5" : stag, "bus_rd", 32'(bus_rd), 32'(e_rd));
      if (e_wr || e_rd) chk("R2", "bus_addr", bus_addr, e_addr);
      if (e_wr) chk("R4", "bus_wdata", bus_wdata, e_wdata);
      chk("R9", "strobe_overlap", 32'(bus_wr && bus_rd), 32'd0);
    end
  end

  task automatic finish_up;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 100000) begin
      failures++;
      $display("FAIL R8 watchdog actual=running expected=done");
      finish_up();
    end
  end

  task automatic acc(input bit w, input logic [4:0] p, input logic [4:0] r,
                     input logic [15:0] d);
    mdio_valid = 1; mdio_write = w; mdio_phy = p; mdio_reg = r; mdio_wdata = d;
    @(negedge clk);
    mdio_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    idle(2);
    acc(0, 5'h17, 5'h01, 0);           // R6 high before any capture -> 0
    acc(0, 5'h18, 5'h00, 0);           // R1 page after reset
    idle(3);
    acc(1, 5'h18, 5'h00, 16'hFFFF);    // R1 truncation to 0x3FF
    acc(0, 5'h18, 5'h00, 0);
    acc(1, 5'h13, 5'h04, 16'h1234);    // R3
    idle(2);
    acc(1, 5'h13, 5'h05, 16'hABCD);    // R4
    acc(0, 5'h17, 5'h1E, 0);           // R5
    acc(0, 5'h17, 5'h1F, 0);           // R6 back-to-back
    idle(3);
    acc(1, 5'h05, 5'h00, 16'h0001);    // R7
    acc(1, 5'h18, 5'h03, 16'h0022);    // R7 not the page register
    acc(1, 5'h19, 5'h00, 16'h0033);    // R7
    acc(0, 5'h0F, 5'h02, 0);           // R7 read
    acc(0, 5'h19, 5'h00, 0);
    acc(0, 5'h18, 5'h00, 0);           // page unchanged
    acc(1, 5'h1F, 5'h01, 16'h5555);
    idle(3);
    for (int pg = 0; pg < 3; pg++) begin
      acc(1, 5'h18, 5'h00, 16'(pg * 341 + 1));
      for (int s = 0; s < 8; s++) begin
        for (int k = 0; k < 16; k++) begin
          acc(1, 5'(16 + s), 5'(2 * k), 16'(k * 4099 + s));
          acc(1, 5'(16 + s), 5'(2 * k + 1), 16'(s * 257 + pg));
          acc(0, 5'(16 + s), 5'(2 * k), 0);
          if (k % 3 == 0) idle(1);
          acc(0, 5'(16 + s), 5'(2 * k + 1), 0);
          if (k % 4 == 0) acc(0, 5'(k), 5'(s), 0);
        end
      end
    end
    acc(1, 5'h18, 5'h00, 16'h0000);
    acc(0, 5'h10, 5'h00, 0);
    acc(0, 5'h10, 5'h01, 0);
    idle(5);
    rst = 1;
    idle(2);
    rst = 0;
    acc(0, 5'h18, 5'h00, 0);           // R1 reset value again
    idle(5);
    finish_up();
  end
endmodule